// File: doc/BRIEF.md
# Serial Word Master with Transmit Holding Register

This block is a synchronous serial master that moves 24-bit words, MSB first, over a four-wire link: it drives the serial clock, one active-low slave select and the outbound data line, and samples the inbound data line. The serial clock is derived from the system clock by a programmable divider. Two configuration inputs pick the idle level of the serial clock and whether data is captured on the first or the second edge of each bit.

Software-side logic writes a word into a transmit holding register. When the shifter is free, the word moves into it at once and the transfer begins on the next clock. A word written while another is in flight waits in the holding register. The transmit-empty flag rises only when the last serial clock edge of a word has happened and nothing is waiting. Between two words the select line is always released for one full serial clock period and then driven low again. Each received word lands in a read register and raises a receive-full flag. A read strobe clears that flag.

Top module: `spi_word_master`

## Requirements
- R1: After reset, ss_n is 1, tx_empty is 1 and rx_full is 0. While ss_n is high, sclk equals cfg_cpol.
- R2: With divider value N on cfg_div, every sclk level inside a word lasts exactly N+1 clock cycles, so sclk runs at clk/(2*(N+1)). A word has 48 sclk edges.
- R3: With cfg_cpha=0, mosi shows the word's bit 23 from the cycle ss_n falls. Data is captured from miso on edges 1, 3, 5 and so on (the leading edges), and mosi moves to the next bit on the trailing edges.
- R4: With cfg_cpha=1, mosi moves to the next bit on each leading edge after the first, and data is captured from miso on the trailing edges.
- R5: A tx_wr pulse while the block is idle takes effect on that clock edge: in the next cycle ss_n is 0 and tx_empty is 0.
- R6: tx_empty stays 0 from a write until the word's final sclk edge. It rises on that edge only if no word is waiting.
- R7: ss_n falls exactly N+1 cycles before the first sclk edge and rises on the last sclk edge. It then stays high for exactly 2*(N+1) cycles before the next word starts.
- R8: The 24 bits received during a word, first bit as bit 23, appear on rx_data at the last sclk edge, together with rx_full=1. rx_rd clears rx_full, and a set in the same cycle wins.
- R9: A word written while another is being shifted starts after the select gap. A second such write before that start replaces the waiting word. In the gap, one word can be held in the shifter and one in the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Idle level of sclk |
| cfg_cpha | input | 1 | 0: capture on leading edge, 1: capture on trailing edge |
| cfg_div | input | 8 | Divider value N; half period is N+1 clocks |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | 24 | Word to transmit |
| tx_empty | output | 1 | No word is being sent or waiting |
| rx_rd | input | 1 | Clears rx_full |
| rx_data | output | 24 | Last received word |
| rx_full | output | 1 | A word was received since the last rx_rd |
| sclk | output | 1 | Serial clock |
| ss_n | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench builds the block with its default 24-bit word and 8-bit divider, and drives cfg_div to 0, 1, 2 and 3. The fastest setting puts an sclk edge on every clock, so the first-edge and last-edge timing meet the select gap with no slack. The slower settings make the lead time and the gap length differ from one edge, so a miscounted half period shows up. All four polarity and phase combinations are covered, and the queued, replaced and in-gap writes are run with a divider large enough that each write lands where intended.

// File: rtl/spi_word_pkg.sv
package spi_word_pkg;

    // Sequencer phases of one word on the link
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,   // select released, nothing to send
        PH_LEAD  = 2'd1,   // select low, waiting for the first edge
        PH_SHIFT = 2'd2,   // edges running
        PH_GAP   = 2'd3    // select released between words
    } spi_phase_e;

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             tick
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign tick = !restart && (cnt_q == limit);

    always_comb begin
        cnt_d = cnt_q + CNT_W'(1);
        if (restart || tick) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/spi_shift_path.sv
module spi_shift_path #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift_en,
    input  logic              capture_en,
    input  logic              miso,
    output logic              mosi,
    output logic [WORD_W-1:0] rx_assembled
);

    typedef struct packed {
        logic [WORD_W-1:0] tx;
        logic [WORD_W-1:0] rx;
    } path_t;

    path_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.tx = load_word;
        end else if (shift_en) begin
            r_d.tx = {r_q.tx[WORD_W-2:0], 1'b0};
        end
        if (capture_en) begin
            r_d.rx = {r_q.rx[WORD_W-2:0], miso};
        end
    end

    assign mosi         = r_q.tx[WORD_W-1];
    assign rx_assembled = r_d.rx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
    import spi_word_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              tx_wr,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_empty,
    input  logic              rx_rd,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_full,
    output logic              sclk,
    output logic              ss_n,
    output logic              mosi,
    input  logic              miso
);

    localparam int EDGES     = 2 * WORD_W;
    localparam int EDGE_W    = $clog2(EDGES);
    localparam int CNT_W     = DIV_W + 1;
    localparam logic [EDGE_W-1:0] EDGE_LAST = EDGE_W'(EDGES - 1);

    typedef struct packed {
        spi_phase_e        ph;
        logic [EDGE_W-1:0] edge_idx;
        logic              sclk;
        logic              loaded;   // shifter owns a word not yet finished
        logic              pend;     // holding register owns a waiting word
        logic [WORD_W-1:0] hold;
        logic [WORD_W-1:0] rx_word;
        logic              rx_full;
    } ctrl_t;

    ctrl_t r_d, r_q;

    logic              tick;
    logic [CNT_W-1:0]  timer_limit;
    logic              timer_restart;
    logic              fire;
    logic              last_edge;
    logic              cap_edge;
    logic              shift_edge;
    logic              word_end;
    logic              load_shifter;
    logic [WORD_W-1:0] load_word;
    logic [WORD_W-1:0] rx_assembled;

    // Half period of N+1 clocks while shifting, a full period in the gap
    assign timer_restart = (r_q.ph == PH_IDLE);
    assign timer_limit   = (r_q.ph == PH_GAP) ? {cfg_div, 1'b1} : {1'b0, cfg_div};

    spi_half_timer #(
        .CNT_W (CNT_W)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (timer_restart),
        .limit   (timer_limit),
        .tick    (tick)
    );

    // Edge classification: even index is a leading edge
    assign fire       = tick && ((r_q.ph == PH_LEAD) || (r_q.ph == PH_SHIFT));
    assign last_edge  = (r_q.edge_idx == EDGE_LAST);
    assign cap_edge   = fire && (r_q.edge_idx[0] == cfg_cpha);
    assign shift_edge = fire && (r_q.edge_idx[0] != cfg_cpha)
                        && !(cfg_cpha && (r_q.edge_idx == '0));
    assign word_end   = fire && last_edge;

    always_comb begin
        r_d          = r_q;
        load_shifter = 1'b0;
        load_word    = tx_data;

        // Serial clock: parked at idle level outside the edge run
        if (r_q.ph != PH_SHIFT) begin
            r_d.sclk = cfg_cpol;
        end
        if (fire) begin
            r_d.sclk = ~r_q.sclk;
            if (last_edge) begin
                r_d.ph = PH_GAP;
            end else begin
                r_d.edge_idx = r_q.edge_idx + EDGE_W'(1);
                r_d.ph       = PH_SHIFT;
            end
        end

        // Receive side
        if (rx_rd) begin
            r_d.rx_full = 1'b0;
        end
        if (word_end) begin
            r_d.rx_word = rx_assembled;
            r_d.rx_full = 1'b1;
        end

        // Completion frees the shifter; a waiting word moves in
        if (word_end) begin
            if (r_q.pend) begin
                load_shifter = 1'b1;
                load_word    = r_q.hold;
                r_d.pend     = 1'b0;
                r_d.loaded   = 1'b1;
            end else begin
                r_d.loaded = 1'b0;
            end
        end

        // New word: into the shifter when free, else into holding
        if (tx_wr) begin
            if (!r_d.loaded) begin
                load_shifter = 1'b1;
                load_word    = tx_data;
                r_d.loaded   = 1'b1;
            end else begin
                r_d.hold = tx_data;
                r_d.pend = 1'b1;
            end
        end

        // Starting a word
        case (r_q.ph)
            PH_IDLE: begin
                if (r_d.loaded) begin
                    r_d.ph       = PH_LEAD;
                    r_d.edge_idx = '0;
                end
            end
            PH_GAP: begin
                if (tick) begin
                    r_d.ph       = r_d.loaded ? PH_LEAD : PH_IDLE;
                    r_d.edge_idx = '0;
                end
            end
            default: begin
            end
        endcase
    end

    spi_shift_path #(
        .WORD_W (WORD_W)
    ) i_path (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load_shifter),
        .load_word    (load_word),
        .shift_en     (shift_edge),
        .capture_en   (cap_edge),
        .miso         (miso),
        .mosi         (mosi),
        .rx_assembled (rx_assembled)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.ph       <= PH_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sclk     = r_q.sclk;
    assign ss_n     = (r_q.ph == PH_IDLE) || (r_q.ph == PH_GAP);
    assign tx_empty = !r_q.loaded;
    assign rx_data  = r_q.rx_word;
    assign rx_full  = r_q.rx_full;

endmodule

// File: rtl/spi_word_master_chk.sv
module spi_word_master_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_cpol,
    input logic tx_wr,
    input logic tx_empty,
    input logic rx_full,
    input logic sclk,
    input logic ss_n,
    input logic mosi
);

    // R1: deselected link keeps sclk at the idle level
    p_idle_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n && $past(rst_n) |-> sclk == $past(cfg_cpol));

    // R7: select falls with sclk still at the idle level
    p_select_lead_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ss_n) |-> sclk == cfg_cpol);

    // R3 / R4: outbound data only moves together with an sclk edge
    p_mosi_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_n && $past(!ss_n) && !$stable(mosi) |-> !$stable(sclk));

    // R5: an accepted write makes the register non-empty
    p_write_fills_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |=> !tx_empty);

    // R6: empty only returns at the end of a word
    p_empty_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_empty) |-> $rose(ss_n));

    // R8: receive flag is raised only when a word completes
    p_rx_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $rose(ss_n));

endmodule

bind spi_word_master spi_word_master_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_cpol (cfg_cpol),
    .tx_wr    (tx_wr),
    .tx_empty (tx_empty),
    .rx_full  (rx_full),
    .sclk     (sclk),
    .ss_n     (ss_n),
    .mosi     (mosi)
);

// File: tb/test_spi_word_master.sv
`timescale 1ns/1ps
module test_spi_word_master;

    localparam int W  = 24;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_cpol = 1'b0;
    logic          cfg_cpha = 1'b0;
    logic [DW-1:0] cfg_div = '0;
    logic          tx_wr = 1'b0;
    logic [W-1:0]  tx_data = '0;
    logic          tx_empty;
    logic          rx_rd = 1'b0;
    logic [W-1:0]  rx_data;
    logic          rx_full;
    logic          sclk;
    logic          ss_n;
    logic          mosi;
    logic          miso = 1'b0;

    always #2.5 clk = ~clk;

    spi_word_master #(.WORD_W(W), .DIV_W(DW)) i_spi_word_master (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_div(cfg_div), .tx_wr(tx_wr), .tx_data(tx_data), .tx_empty(tx_empty),
        .rx_rd(rx_rd), .rx_data(rx_data), .rx_full(rx_full), .sclk(sclk),
        .ss_n(ss_n), .mosi(mosi), .miso(miso)
    );

    int n_chk = 0;
    int n_err = 0;
    bit run_chk = 0;
    bit done = 0;

    // Behavioural reference: elapsed cycles since a word started, plus a queue
    bit          m_act;
    int          m_t;
    int          m_h;
    bit          m_pol, m_pha, m_fromq;
    logic [W-1:0] m_cur;
    logic [W-1:0] m_q[$];
    logic [W-1:0] m_rx;
    bit          m_full;

    function automatic logic [W-1:0] slave_of(input logic [W-1:0] w);
        return {w[W/2-1:0], w[W-1:W/2]} ^ 24'h5A5A5A;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_t = 0; m_q.delete(); m_rx = '0; m_full = 0;
            m_pol = cfg_cpol; m_pha = cfg_cpha; m_h = int'(cfg_div) + 1; m_fromq = 0;
        end else begin
            m_pol = cfg_cpol; m_pha = cfg_cpha; m_h = int'(cfg_div) + 1;
            if (rx_rd) m_full = 0;
            if (m_act) begin
                m_t++;
                if (m_t == 2*W*m_h) begin
                    m_rx = slave_of(m_cur);
                    m_full = 1;
                end
                if (m_t == 2*W*m_h + 2*m_h) begin
                    if (m_q.size() > 0) begin
                        m_cur = m_q.pop_front(); m_t = 0; m_fromq = 1;
                    end else begin
                        m_act = 0;
                    end
                end
            end
            if (tx_wr) begin
                if (!m_act) begin
                    m_act = 1; m_t = 0; m_cur = tx_data; m_fromq = 0;
                end else if (m_t < 2*W*m_h) begin
                    if (m_q.size() >= 1) m_q[m_q.size()-1] = tx_data;
                    else m_q.push_back(tx_data);
                end else begin
                    if (m_q.size() >= 2) m_q[1] = tx_data;
                    else m_q.push_back(tx_data);
                end
            end
        end
    end

    // Compare every cycle, then present the next inbound bit
    always @(negedge clk) begin : cmp
        int tog;
        int sh;
        int cap;
        bit busy;
        bit e_ss;
        bit e_empty;
        string rq;
        busy = m_act && (m_t < 2*W*m_h);
        tog  = !m_act ? 0 : (busy ? m_t / m_h : 2*W);
        if (rst_n && run_chk) begin
            e_ss    = !busy;
            e_empty = (m_q.size() == 0) && !busy;
            chk(ss_n == e_ss, "R7 select", W'(ss_n), W'(e_ss));
            chk(sclk == (m_pol ^ tog[0]), m_act ? "R2 sclk" : "R1 idle sclk",
                W'(sclk), W'(m_pol ^ tog[0]));
            chk(tx_empty == e_empty, "R6 tx_empty", W'(tx_empty), W'(e_empty));
            chk(rx_full == m_full, "R8 rx_full", W'(rx_full), W'(m_full));
            chk(rx_data == m_rx, "R8 rx_data", rx_data, m_rx);
            if (busy) begin
                sh = m_pha ? ((tog > 0) ? (tog - 1) / 2 : 0) : tog / 2;
                rq = m_fromq ? "R9 queued mosi" : (m_pha ? "R4 mosi" : "R3 mosi");
                chk(mosi == m_cur[W-1-sh], rq, W'(mosi), W'(m_cur[W-1-sh]));
            end
        end
        cap = m_pha ? tog / 2 : (tog + 1) / 2;
        miso <= (busy && cap < W) ? slave_of(m_cur)[W-1-cap] : 1'b0;
    end

    task automatic set_cfg(input bit pol, input bit pha, input int n);
        @(negedge clk);
        cfg_cpol = pol; cfg_cpha = pha; cfg_div = DW'(n);
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_wr(input logic [W-1:0] w);
        @(negedge clk);
        tx_wr = 1'b1; tx_data = w;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    // R5: write from idle starts the word on the same edge
    task automatic send_idle(input logic [W-1:0] w);
        pulse_wr(w);
        chk(ss_n == 1'b0, "R5 select low", W'(ss_n), W'(0));
        chk(tx_empty == 1'b0, "R5 tx_empty low", W'(tx_empty), W'(0));
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_act) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic read_rx();
        @(negedge clk);
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
        chk(rx_full == 1'b0, "R8 rx_rd clears", W'(rx_full), W'(0));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(ss_n == 1'b1, "R1 reset ss_n", W'(ss_n), W'(1));
        chk(tx_empty == 1'b1, "R1 reset tx_empty", W'(tx_empty), W'(1));
        chk(rx_full == 1'b0, "R1 reset rx_full", W'(rx_full), W'(0));
        chk(sclk == cfg_cpol, "R1 reset sclk", W'(sclk), W'(cfg_cpol));
        run_chk = 1;

        // R3 at the fastest rate
        set_cfg(0, 0, 0);
        send_idle(24'hA5C3F1);
        wait_idle();
        read_rx();

        // R1 high idle level, R3
        set_cfg(1, 0, 1);
        send_idle(24'h800001);
        wait_idle();
        read_rx();

        // R4 with a slower rate
        set_cfg(0, 1, 3);
        send_idle(24'h3C96E7);
        wait_idle();

        // R4 and R9: word queued during a transfer, R8 set-over-clear skipped
        set_cfg(1, 1, 2);
        send_idle(24'h123456);
        repeat (30) @(negedge clk);
        pulse_wr(24'hFEDCBA);
        wait_idle();
        read_rx();

        // R9: second write while one waits replaces it
        set_cfg(0, 0, 2);
        send_idle(24'h0F0F0F);
        repeat (20) @(negedge clk);
        pulse_wr(24'hDEAD00);
        repeat (5) @(negedge clk);
        pulse_wr(24'h00BEEF);
        wait_idle();

        // R9: two writes inside the select gap
        send_idle(24'h777777);
        @(negedge clk);
        while (!tx_empty) @(negedge clk);
        tx_wr = 1'b1; tx_data = 24'hC0FFEE;
        @(negedge clk);
        tx_data = 24'h5EED11;
        @(negedge clk);
        tx_wr = 1'b0;
        wait_idle();
        read_rx();

        finish_run();
    end

endmodule